// File: doc/BRIEF.md
# Credit-Based Transmit Permission Gate

This block sits on the transmit side of a packet link and decides, one cycle at a time, whether the packet waiting to go out may be sent. The far receiver advertises how many buffer credits it has, and the gate keeps two wrapping counters. One is the credit limit. It is loaded by the advertisement and raised by later credit returns. The other is the running total of credits spent by packets already sent. A packet is allowed only when sending it would keep the spent total within the limit. The comparison is modular, so both counters may wrap freely.

The transmitter presents the cost of its pending packet on `pkt_cost` and watches `tx_permit`. When it actually sends the packet it pulses `tx_fire` in the same cycle. Credit returns arrive as single-cycle events. Each event either adds an amount to the limit or replaces the limit outright. An advertisement of zero puts the gate into unlimited mode, in which every packet is allowed.

The gate holds no credit from reset until the first advertisement arrives. A new advertisement may be applied at any later time, and it restarts the accounting.

Top module: `txcred_gate`

## Requirements
- R1: From reset until the first `adv_valid` pulse, `tx_permit` is 0 for every cost.
- R2: An `adv_valid` pulse loads the limit from `adv_credit`, clears the spent count to 0, and makes the gate ready from the next cycle.
- R3: While ready and not unlimited, `tx_permit` is 1 exactly when ((limit − (spent + `pkt_cost`)) mod 2^CW) ≤ 2^(CW−1). With CW = 8, a gap of 128 permits and a gap of 129 does not. The permit is combinational on `pkt_cost` and the registered counters.
- R4: A cycle with `tx_fire`=1 and `tx_permit`=1 adds `pkt_cost` to the spent count modulo 2^CW. A `tx_fire` pulse while `tx_permit` is 0 changes nothing.
- R5: A `ret_valid` pulse with `ret_kind`=0 adds `ret_value` to the limit modulo 2^CW. With `ret_kind`=1 it sets the limit to `ret_value`. Either way the change takes effect from the next cycle.
- R6: An advertisement of 0 selects unlimited mode. In this mode `tx_permit` is 1 for every cost and credit returns are ignored. The mode lasts until the next advertisement.
- R7: A send and a credit return in the same cycle are both applied. The permit in that cycle is judged on the counter values from before it.
- R8: When `adv_valid` coincides with `tx_fire` or `ret_valid`, only the advertisement takes effect.
- R9: Both counters wrap through zero, and the permit stays correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_valid | input | 1 | Initial credit advertisement strobe |
| adv_credit | input | CW | Advertised credit amount (0 = unlimited) |
| pkt_cost | input | CW | Credit cost of the pending packet |
| tx_fire | input | 1 | Pending packet is sent this cycle |
| ret_valid | input | 1 | Credit return event strobe |
| ret_kind | input | 1 | 0 = add `ret_value` to the limit, 1 = set the limit to it |
| ret_value | input | CW | Credit amount or new limit |
| tx_permit | output | 1 | Pending packet may be sent |

## Verification
Two situations are hard to reach from the ports. One is the wrap of the spent counter through zero while the limit has already wrapped. The other is a gap of exactly half the counter range. The stimulus reaches the wrap by repeatedly spending large costs and returning matching credit. It reaches the half-range gap by presenting, just after an advertisement of 10, costs of 138 and 137, which sit on either side of the modular window. A long mixed phase then draws costs, sends, returns and occasional re-advertisements at random, while a behavioural model predicts the permit on every cycle.

// File: rtl/txcred_pkg.sv
package txcred_pkg;

  typedef enum logic {
    RET_ADD = 1'b0,
    RET_SET = 1'b1
  } ret_kind_e;

  typedef struct packed {
    logic ready;
    logic unlimited;
  } gate_mode_t;

endpackage

// File: rtl/txcred_limit.sv
module txcred_limit
  import txcred_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_valid,
  input  logic [CW-1:0] adv_credit,
  input  logic          ret_valid,
  input  ret_kind_e     ret_kind,
  input  logic [CW-1:0] ret_value,
  output logic [CW-1:0] limit_q,
  output gate_mode_t    mode_q
);

  logic          apply_ret;
  logic [CW-1:0] limit_d;

  assign apply_ret = ret_valid && mode_q.ready && !mode_q.unlimited && !adv_valid;

  always_comb begin
    limit_d = limit_q;
    if (adv_valid) begin
      limit_d = adv_credit;
    end else if (apply_ret) begin
      if (ret_kind == RET_SET) limit_d = ret_value;
      else                     limit_d = limit_q + ret_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      limit_q <= '0;
      mode_q  <= '{ready: 1'b0, unlimited: 1'b0};
    end else begin
      limit_q <= limit_d;
      if (adv_valid) begin
        mode_q.ready     <= 1'b1;
        mode_q.unlimited <= (adv_credit == '0);
      end
    end
  end

  // R2: advertisement loads limit and readiness
  a_r2_adv_loads: assert property (@(posedge clk) disable iff (rst)
    adv_valid |=> (limit_q == $past(adv_credit)) && mode_q.ready);

  // R5: additive return
  a_r5_ret_add: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_kind == RET_ADD && mode_q.ready && !mode_q.unlimited && !adv_valid)
    |=> limit_q == CW'($past(limit_q) + $past(ret_value)));

  // R5: absolute return
  a_r5_ret_set: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && ret_kind == RET_SET && mode_q.ready && !mode_q.unlimited && !adv_valid)
    |=> limit_q == $past(ret_value));

  // R6: unlimited mode ignores returns
  a_r6_unl_frozen: assert property (@(posedge clk) disable iff (rst)
    (mode_q.unlimited && !adv_valid) |=> $stable(limit_q) && mode_q.unlimited);

  // R1: limit does not move before the first advertisement
  a_r1_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (!mode_q.ready && !adv_valid) |=> $stable(limit_q) && !mode_q.ready);

endmodule

// File: rtl/txcred_spent.sv
module txcred_spent #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_valid,
  input  logic          take,
  input  logic [CW-1:0] pkt_cost,
  output logic [CW-1:0] spent_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      spent_q <= '0;
    end else if (adv_valid) begin
      spent_q <= '0;
    end else if (take) begin
      spent_q <= spent_q + pkt_cost;
    end
  end

  // R4: accepted send accumulates its cost
  a_r4_take_adds: assert property (@(posedge clk) disable iff (rst)
    (take && !adv_valid) |=> spent_q == CW'($past(spent_q) + $past(pkt_cost)));

  // R4: no accepted send, no change
  a_r4_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (!take && !adv_valid) |=> $stable(spent_q));

  // R8: advertisement wins and clears the count
  a_r8_adv_clears: assert property (@(posedge clk) disable iff (rst)
    adv_valid |=> spent_q == '0);

endmodule

// File: rtl/txcred_check.sv
module txcred_check
  import txcred_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] limit_q,
  input  logic [CW-1:0] spent_q,
  input  logic [CW-1:0] pkt_cost,
  input  gate_mode_t    mode_q,
  output logic          permit
);

  localparam logic [CW-1:0] HALF = CW'(1) << (CW - 1);

  logic [CW-1:0] need;
  logic [CW-1:0] gap;
  logic          fits;

  assign need   = spent_q + pkt_cost;
  assign gap    = limit_q - need;
  assign fits   = (gap <= HALF);
  assign permit = mode_q.ready && (mode_q.unlimited || fits);

  // R1: nothing is permitted before readiness
  a_r1_no_permit_unready: assert property (@(posedge clk) disable iff (rst)
    !mode_q.ready |-> !permit);

  // R6: unlimited mode always permits
  a_r6_unl_permit: assert property (@(posedge clk) disable iff (rst)
    (mode_q.ready && mode_q.unlimited) |-> permit);

  // R3: zero cost with equal counters is always allowed
  a_r3_zero_gap_ok: assert property (@(posedge clk) disable iff (rst)
    (mode_q.ready && pkt_cost == '0 && spent_q == limit_q) |-> permit);

endmodule

// File: rtl/txcred_gate.sv
module txcred_gate
  import txcred_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv_valid,
  input  logic [CW-1:0] adv_credit,
  input  logic [CW-1:0] pkt_cost,
  input  logic          tx_fire,
  input  logic          ret_valid,
  input  logic          ret_kind,
  input  logic [CW-1:0] ret_value,
  output logic          tx_permit
);

  logic [CW-1:0] limit_q;
  logic [CW-1:0] spent_q;
  gate_mode_t    mode_q;
  logic          take;

  assign take = tx_fire && tx_permit;

  txcred_limit #(.CW(CW)) u_limit (
    .clk        (clk),
    .rst        (rst),
    .adv_valid  (adv_valid),
    .adv_credit (adv_credit),
    .ret_valid  (ret_valid),
    .ret_kind   (ret_kind_e'(ret_kind)),
    .ret_value  (ret_value),
    .limit_q    (limit_q),
    .mode_q     (mode_q)
  );

  txcred_spent #(.CW(CW)) u_spent (
    .clk       (clk),
    .rst       (rst),
    .adv_valid (adv_valid),
    .take      (take),
    .pkt_cost  (pkt_cost),
    .spent_q   (spent_q)
  );

  txcred_check #(.CW(CW)) u_check (
    .clk      (clk),
    .rst      (rst),
    .limit_q  (limit_q),
    .spent_q  (spent_q),
    .pkt_cost (pkt_cost),
    .mode_q   (mode_q),
    .permit   (tx_permit)
  );

  // R1: first cycle out of reset grants nothing
  a_r1_reset_closed: assert property (@(posedge clk)
    $past(rst) |-> !tx_permit);

endmodule

// File: tb/sim_txcred_gate.sv
`timescale 1ns/1ps
module sim_txcred_gate;

  localparam int CW   = 8;
  localparam int MASK = (1 << CW) - 1;
  localparam int HALF = 1 << (CW - 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          adv_valid = 1'b0;
  logic [CW-1:0] adv_credit = '0;
  logic [CW-1:0] pkt_cost = '0;
  logic          tx_fire = 1'b0;
  logic          ret_valid = 1'b0;
  logic          ret_kind = 1'b0;
  logic [CW-1:0] ret_value = '0;
  logic          tx_permit;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int m_lim = 0, m_spent = 0;
  bit m_rdy = 0, m_unl = 0;

  always #5 clk = ~clk;

  txcred_gate #(.CW(CW)) u0 (
    .clk(clk), .rst(rst), .adv_valid(adv_valid), .adv_credit(adv_credit),
    .pkt_cost(pkt_cost), .tx_fire(tx_fire), .ret_valid(ret_valid),
    .ret_kind(ret_kind), .ret_value(ret_value), .tx_permit(tx_permit)
  );

  function automatic bit model_permit(int cost);
    if (!m_rdy) return 1'b0;
    if (m_unl) return 1'b1;
    return (((m_lim - (m_spent + cost)) & MASK) <= HALF);
  endfunction

  task automatic step(input bit av, input int ac, input int cost, input bit fire,
                      input bit rv, input bit rk, input int rval, input string tag);
    bit exp;
    @(negedge clk);
    adv_valid = av; adv_credit = CW'(ac); pkt_cost = CW'(cost);
    tx_fire = fire; ret_valid = rv; ret_kind = rk; ret_value = CW'(rval);
    #1;
    exp = model_permit(cost);
    total++;
    if (tx_permit !== exp) begin
      bad++;
      $display("FAIL %s: cost=%0d permit actual=%0b expected=%0b", tag, cost, tx_permit, exp);
    end
    if (av) begin
      m_lim = ac & MASK; m_spent = 0; m_rdy = 1; m_unl = ((ac & MASK) == 0);
    end else if (m_rdy) begin
      if (fire && exp) m_spent = (m_spent + cost) & MASK;
      if (rv && !m_unl) m_lim = rk ? (rval & MASK) : ((m_lim + rval) & MASK);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1: closed before advertisement, even with fire and returns
    step(0, 0, 0, 1, 0, 0, 0, "R1");
    step(0, 0, 5, 1, 1, 0, 50, "R1");
    step(0, 0, 0, 0, 1, 1, 9, "R1");
    // R2 advertisement of 10
    step(1, 10, 0, 0, 0, 0, 0, "R2");
    step(0, 0, 10, 0, 0, 0, 0, "R2");
    step(0, 0, 11, 0, 0, 0, 0, "R3");
    step(0, 0, 138, 0, 0, 0, 0, "R3");
    step(0, 0, 137, 0, 0, 0, 0, "R3");
    // R4 accepted send, then ignored send
    step(0, 0, 4, 1, 0, 0, 0, "R4");
    step(0, 0, 6, 0, 0, 0, 0, "R4");
    step(0, 0, 7, 1, 0, 0, 0, "R4");
    step(0, 0, 6, 0, 0, 0, 0, "R4");
    step(0, 0, 7, 0, 0, 0, 0, "R4");
    // R5 add and set
    step(0, 0, 0, 0, 1, 0, 5, "R5");
    step(0, 0, 11, 0, 0, 0, 0, "R5");
    step(0, 0, 12, 0, 0, 0, 0, "R5");
    step(0, 0, 0, 0, 1, 1, 20, "R5");
    step(0, 0, 16, 0, 0, 0, 0, "R5");
    step(0, 0, 17, 0, 0, 0, 0, "R5");
    // R7 send and return together
    step(0, 0, 3, 1, 1, 0, 2, "R7");
    step(0, 0, 15, 0, 0, 0, 0, "R7");
    step(0, 0, 16, 0, 0, 0, 0, "R7");
    step(0, 0, 17, 1, 1, 0, 10, "R7");
    step(0, 0, 25, 0, 0, 0, 0, "R7");
    step(0, 0, 26, 0, 0, 0, 0, "R7");
    // R8 advertisement wins over send and return
    step(1, 30, 5, 1, 1, 1, 200, "R8");
    step(0, 0, 30, 0, 0, 0, 0, "R8");
    step(0, 0, 31, 0, 0, 0, 0, "R8");
    // R6 unlimited
    step(1, 0, 0, 0, 0, 0, 0, "R6");
    step(0, 0, 255, 1, 0, 0, 0, "R6");
    step(0, 0, 0, 0, 1, 1, 1, "R6");
    step(0, 0, 255, 0, 0, 0, 0, "R6");
    step(0, 0, 200, 1, 1, 0, 3, "R6");
    step(0, 0, 129, 0, 0, 0, 0, "R6");
    // R9 wrap of both counters
    step(1, 120, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 12; i++) begin
      step(0, 0, 100, 1, 1, 0, 100, "R9");
      step(0, 0, 120, 0, 0, 0, 0, "R9");
      step(0, 0, 121, 0, 0, 0, 0, "R9");
    end
    // mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      int c;
      c = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255) : $urandom_range(0, 24);
      step(($urandom_range(0, 99) == 0), $urandom_range(0, 60), c,
           $urandom_range(0, 1), ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
           $urandom_range(0, 30), "R3");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule